// File: doc/BRIEF.md
# Interval Product Endpoint Selector

This block finishes an interval multiplication in which each interval is stored as a lower and an upper endpoint. Upstream, four multipliers form the cross products of the operand endpoints, and each delivers two results: one rounded toward minus infinity and one rounded toward plus infinity. The block reads only the sign bits of the four operand endpoints. From them it decides which cross product bounds the result from below and which bounds it from above, and it drives the lower and upper endpoints of the result interval.

Each operand falls into one of three classes: entirely non-negative, crossing zero, or entirely negative. Eight of the nine class pairs map directly to one round-down product and one round-up product. When both operands cross zero, two round-down candidates go to a minimum unit and two round-up candidates go to a maximum unit. Both units order the sign-magnitude words with integer compares and need no floating-point hardware. An optional pipeline register after the min/max units carries every product and the class codes with it, so all candidates stay aligned. A valid flag travels with the data, and the latency is fixed.

Words are `1 + EXP_W + FRAC_W` bits wide: sign bit at the top, exponent field below it, fraction field at the bottom. Cross product slot k of `dn_i` and `up_i` holds: k=0 for a1·b1, k=1 for a1·b2, k=2 for a2·b1, k=3 for a2·b2. Sign input `sgn_i` bit 0 is the sign of a1, bit 1 of a2, bit 2 of b1 and bit 3 of b2.

Top module: `ivm_endpoint_sel`

## Requirements
- R1: Each operand is classified from its two sign bits alone. If the lower sign is 0 the operand is non-negative (P). If the lower sign is 1 and the upper sign is 0 it crosses zero (S). If both are 1 it is negative (N). A pattern with lower sign 0 and upper sign 1 is treated as P.
- R2: For class pair (A,B) = (P,P) the result is [dn slot 0, up slot 3]. For (N,N) it is [dn slot 3, up slot 0].
- R3: For (P,S) the result is [dn slot 2, up slot 3]. For (P,N) it is [dn slot 2, up slot 1].
- R4: For (S,P) the result is [dn slot 1, up slot 3]. For (S,N) it is [dn slot 2, up slot 0]. For (N,S) it is [dn slot 1, up slot 0].
- R5: For (N,P) the result is [dn slot 1, up slot 2].
- R6: For (S,S) the lower endpoint is the smaller of dn slots 1 and 2, and the upper endpoint is the larger of up slots 0 and 3.
- R7: The min/max ordering treats the words as sign-magnitude values. A word with sign 1 is below any word with sign 0, including -0 below +0. Among words with sign 0 the larger magnitude is larger. Among words with sign 1 the larger magnitude is smaller.
- R8: `valid_o` equals `valid_i` delayed by 1 + MINMAX_REG clock cycles (2 by default), and the endpoints belonging to an input appear in the same cycle as its `valid_o`.
- R9: While `valid_o` is low, `c1_o` and `c2_o` hold their last values.
- R10: While reset is asserted, `valid_o`, `c1_o` and `c2_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input set is valid |
| sgn_i | input | 4 | Endpoint signs: bit0 a1, bit1 a2, bit2 b1, bit3 b2 |
| dn_i | input | 4 x W | Round-down cross products, slot order a1b1, a1b2, a2b1, a2b2 |
| up_i | input | 4 x W | Round-up cross products, same slot order |
| valid_o | output | 1 | Result valid |
| c1_o | output | W | Lower endpoint of the product interval |
| c2_o | output | W | Upper endpoint of the product interval |

## Verification
The bench covers each of the nine class pairs with unique product words in every slot, so a swapped table entry shows up as a wrong slot value. It also drives the sign pattern with lower sign 0 and upper sign 1; a classifier that looked at the upper sign first would pick the negative-operand row. The straddle case is checked on mixed-sign pairs, on two negative words where an unsigned compare would pick the wrong one, and on the signed-zero pair. Random traffic with gaps in `valid_i` exposes a misaligned delay register or outputs that do not hold during gaps.

// File: rtl/ivm_pkg.sv
package ivm_pkg;

  typedef enum logic [2:0] {
    CLS_POS = 3'b001,
    CLS_STR = 3'b010,
    CLS_NEG = 3'b100
  } cls_e;

  localparam int unsigned N_PROD = 4;
  localparam int unsigned P_A1B1 = 0;
  localparam int unsigned P_A1B2 = 1;
  localparam int unsigned P_A2B1 = 2;
  localparam int unsigned P_A2B2 = 3;

endpackage

// File: rtl/ivm_sign_class.sv
module ivm_sign_class
  import ivm_pkg::*;
(
  input  logic lo_sgn_i,
  input  logic hi_sgn_i,
  output cls_e cls_o
);

  // lower endpoint decides first; bad ordering falls to POS
  always_comb begin
    if (!lo_sgn_i)      cls_o = CLS_POS;
    else if (!hi_sgn_i) cls_o = CLS_STR;
    else                cls_o = CLS_NEG;
  end

endmodule

// File: rtl/ivm_fp_minmax.sv
module ivm_fp_minmax #(
  parameter int unsigned W        = 32,
  parameter bit          PICK_MAX = 1'b0
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] res_o
);

  localparam int unsigned MAG_W = W - 1;

  logic x_sgn, y_sgn;
  logic mag_lt, mag_gt;
  logic x_lt_y;

  assign x_sgn  = x_i[W-1];
  assign y_sgn  = y_i[W-1];
  assign mag_lt = x_i[MAG_W-1:0] < y_i[MAG_W-1:0];
  assign mag_gt = x_i[MAG_W-1:0] > y_i[MAG_W-1:0];

  // sign first, then magnitude, reversed for negatives
  always_comb begin
    if (x_sgn != y_sgn) x_lt_y = x_sgn;
    else if (!x_sgn)    x_lt_y = mag_lt;
    else                x_lt_y = mag_gt;
  end

  generate
    if (PICK_MAX) begin : g_max
      assign res_o = x_lt_y ? y_i : x_i;
    end else begin : g_min
      assign res_o = x_lt_y ? x_i : y_i;
    end
  endgenerate

endmodule

// File: rtl/ivm_pipe_reg.sv
module ivm_pipe_reg #(
  parameter int unsigned W  = 8,
  parameter bit          EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_wire
      assign q_o = d_i;
    end
  endgenerate

endmodule

// File: rtl/ivm_endpoint_sel.sv
module ivm_endpoint_sel
  import ivm_pkg::*;
#(
  parameter int unsigned EXP_W      = 8,
  parameter int unsigned FRAC_W     = 23,
  parameter bit          MINMAX_REG = 1'b1,
  localparam int unsigned W         = 1 + EXP_W + FRAC_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [3:0]             sgn_i,
  input  logic [3:0][W-1:0]      dn_i,
  input  logic [3:0][W-1:0]      up_i,
  output logic                   valid_o,
  output logic [W-1:0]           c1_o,
  output logic [W-1:0]           c2_o
);

  localparam int unsigned LAT   = 1 + (MINMAX_REG ? 1 : 0);
  localparam int unsigned STG_W = 1 + 3 + 3 + 2 * N_PROD * W + 2 * W;

  // operand classes: index 0 = A (a1,a2), index 1 = B (b1,b2)
  cls_e cls_w [2];

  generate
    for (genvar g = 0; g < 2; g++) begin : g_cls
      ivm_sign_class u_cls (
        .lo_sgn_i (sgn_i[2*g]),
        .hi_sgn_i (sgn_i[2*g+1]),
        .cls_o    (cls_w[g])
      );
    end
  endgenerate

  logic [W-1:0] lo_min, hi_max;

  ivm_fp_minmax #(.W(W), .PICK_MAX(1'b0)) u_lo_min (
    .x_i   (dn_i[P_A1B2]),
    .y_i   (dn_i[P_A2B1]),
    .res_o (lo_min)
  );

  ivm_fp_minmax #(.W(W), .PICK_MAX(1'b1)) u_hi_max (
    .x_i   (up_i[P_A1B1]),
    .y_i   (up_i[P_A2B2]),
    .res_o (hi_max)
  );

  // optional stage: min/max results and every product move together
  logic [STG_W-1:0] stg_d, stg_q;

  assign stg_d = {valid_i, cls_w[0], cls_w[1], dn_i, up_i, lo_min, hi_max};

  ivm_pipe_reg #(.W(STG_W), .EN(MINMAX_REG)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stg_d),
    .q_o    (stg_q)
  );

  logic              s_valid;
  logic [2:0]        s_cls_a_raw, s_cls_b_raw;
  logic [3:0][W-1:0] s_dn, s_up;
  logic [W-1:0]      s_min, s_max;
  cls_e              s_cls_a, s_cls_b;

  assign {s_valid, s_cls_a_raw, s_cls_b_raw, s_dn, s_up, s_min, s_max} = stg_q;
  assign s_cls_a = cls_e'(s_cls_a_raw);
  assign s_cls_b = cls_e'(s_cls_b_raw);

  logic [W-1:0] sel_c1, sel_c2;

  always_comb begin
    sel_c1 = s_dn[P_A1B1];
    sel_c2 = s_up[P_A2B2];
    unique case ({s_cls_a, s_cls_b})
      {CLS_POS, CLS_POS}: begin sel_c1 = s_dn[P_A1B1]; sel_c2 = s_up[P_A2B2]; end
      {CLS_POS, CLS_STR}: begin sel_c1 = s_dn[P_A2B1]; sel_c2 = s_up[P_A2B2]; end
      {CLS_POS, CLS_NEG}: begin sel_c1 = s_dn[P_A2B1]; sel_c2 = s_up[P_A1B2]; end
      {CLS_STR, CLS_POS}: begin sel_c1 = s_dn[P_A1B2]; sel_c2 = s_up[P_A2B2]; end
      {CLS_STR, CLS_STR}: begin sel_c1 = s_min;        sel_c2 = s_max;        end
      {CLS_STR, CLS_NEG}: begin sel_c1 = s_dn[P_A2B1]; sel_c2 = s_up[P_A1B1]; end
      {CLS_NEG, CLS_POS}: begin sel_c1 = s_dn[P_A1B2]; sel_c2 = s_up[P_A2B1]; end
      {CLS_NEG, CLS_STR}: begin sel_c1 = s_dn[P_A1B2]; sel_c2 = s_up[P_A1B1]; end
      {CLS_NEG, CLS_NEG}: begin sel_c1 = s_dn[P_A2B2]; sel_c2 = s_up[P_A1B1]; end
      default: ;
    endcase
  end

  logic         valid_q;
  logic [W-1:0] c1_q, c2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      c1_q    <= '0;
      c2_q    <= '0;
    end else begin
      valid_q <= s_valid;
      if (s_valid) begin
        c1_q <= sel_c1;
        c2_q <= sel_c2;
      end
    end
  end

  assign valid_o = valid_q;
  assign c1_o    = c1_q;
  assign c2_o    = c2_q;

  // ---------------- assertions ----------------

  // monotone integer key: independent of the comparator structure
  function automatic logic [W-1:0] ord_key(input logic [W-1:0] v);
    return v[W-1] ? ~v : (v | {1'b1, {(W-1){1'b0}}});
  endfunction

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assert_min_lower_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (ord_key(lo_min) <= ord_key(dn_i[P_A1B2]) &&
                 ord_key(lo_min) <= ord_key(dn_i[P_A2B1])));

  assert_max_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (ord_key(hi_max) >= ord_key(up_i[P_A1B1]) &&
                 ord_key(hi_max) >= ord_key(up_i[P_A2B2])));

  // R7: two negatives in, min must carry the larger magnitude
  assert_neg_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dn_i[P_A1B2][W-1] && dn_i[P_A2B1][W-1]) |->
      (lo_min[W-2:0] >= dn_i[P_A1B2][W-2:0] && lo_min[W-2:0] >= dn_i[P_A2B1][W-2:0]));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(c1_o) && $stable(c2_o)));

  generate
    if (LAT == 2) begin : g_lat2
      assert_valid_lat_R8: assert property (@(posedge clk_i)
        disable iff (!rst_ni || cyc_q < 2'd2)
        valid_o == $past(valid_i, 2));
    end else begin : g_lat1
      assert_valid_lat_R8: assert property (@(posedge clk_i)
        disable iff (!rst_ni || cyc_q < 2'd1)
        valid_o == $past(valid_i, 1));
    end
  endgenerate

endmodule

// File: tb/test_ivm_endpoint_sel.sv
module test_ivm_endpoint_sel;

  localparam int W   = 32;
  localparam int LAT = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              valid_i;
  logic [3:0]        sgn_i;
  logic [3:0][W-1:0] dn_i, up_i;
  logic              valid_o;
  logic [W-1:0]      c1_o, c2_o;

  always #5 clk = ~clk;

  ivm_endpoint_sel i_ivm_endpoint_sel (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (valid_i),
    .sgn_i   (sgn_i),
    .dn_i    (dn_i),
    .up_i    (up_i),
    .valid_o (valid_o),
    .c1_o    (c1_o),
    .c2_o    (c2_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [2*W-1:0] exp_q[$];
  string          tag_q[$];
  logic [LAT-1:0] vhist;
  logic [W-1:0]   last_c1, last_c2;

  function automatic logic [W-1:0] key(input logic [W-1:0] v);
    return v[W-1] ? ~v : (v | {1'b1, {(W-1){1'b0}}});
  endfunction

  function automatic logic [W-1:0] fmin(input logic [W-1:0] x, input logic [W-1:0] y);
    return (key(x) <= key(y)) ? x : y;
  endfunction

  function automatic logic [W-1:0] fmax(input logic [W-1:0] x, input logic [W-1:0] y);
    return (key(x) >= key(y)) ? x : y;
  endfunction

  // 0 = P, 1 = S, 2 = N
  function automatic int cls(input logic lo, input logic hi);
    return !lo ? 0 : (!hi ? 1 : 2);
  endfunction

  function automatic void model(input logic [3:0] s,
                                input logic [3:0][W-1:0] dn,
                                input logic [3:0][W-1:0] up,
                                output logic [W-1:0] c1,
                                output logic [W-1:0] c2,
                                output string tg);
    int ca, cb;
    ca = cls(s[0], s[1]);
    cb = cls(s[2], s[3]);
    case (ca * 3 + cb)
      0: begin c1 = dn[0]; c2 = up[3]; tg = "R2"; end
      1: begin c1 = dn[2]; c2 = up[3]; tg = "R3"; end
      2: begin c1 = dn[2]; c2 = up[1]; tg = "R3"; end
      3: begin c1 = dn[1]; c2 = up[3]; tg = "R4"; end
      4: begin c1 = fmin(dn[1], dn[2]); c2 = fmax(up[0], up[3]); tg = "R6"; end
      5: begin c1 = dn[2]; c2 = up[0]; tg = "R4"; end
      6: begin c1 = dn[1]; c2 = up[2]; tg = "R5"; end
      7: begin c1 = dn[1]; c2 = up[0]; tg = "R4"; end
      default: begin c1 = dn[3]; c2 = up[0]; tg = "R2"; end
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // called at a negedge: check outputs, then drive the next input set
  task automatic step(input logic v, input logic [3:0] s,
                      input logic [3:0][W-1:0] dn, input logic [3:0][W-1:0] up,
                      input string tg_ovr);
    logic [W-1:0] e1, e2;
    string tg;
    check("R8", W'(valid_o), W'(vhist[LAT-1]));
    if (valid_o) begin
      if (exp_q.size() > 0) begin
        {e1, e2} = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, c1_o, e1);
        check(tg, c2_o, e2);
      end
      last_c1 = c1_o;
      last_c2 = c2_o;
    end else begin
      check("R9", c1_o, last_c1);
      check("R9", c2_o, last_c2);
    end
    vhist   = {vhist[LAT-2:0], v};
    valid_i = v;
    sgn_i   = s;
    dn_i    = dn;
    up_i    = up;
    if (v) begin
      model(s, dn, up, e1, e2, tg);
      exp_q.push_back({e1, e2});
      tag_q.push_back(tg_ovr != "" ? tg_ovr : tg);
    end
    @(negedge clk);
  endtask

  task automatic uniq(output logic [3:0][W-1:0] dn, output logic [3:0][W-1:0] up);
    for (int k = 0; k < 4; k++) begin
      dn[k] = 32'h3f80_0000 + W'(k);
      up[k] = 32'h4000_0000 + W'(k);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0][W-1:0] dn, up;
    void'($urandom(32'd20240611));
    rst_n   = 1'b0;
    valid_i = 1'b0;
    sgn_i   = '0;
    dn_i    = '0;
    up_i    = '0;
    vhist   = '0;
    last_c1 = '0;
    last_c2 = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", W'(valid_o), '0);
    check("R10", c1_o, '0);
    check("R10", c2_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // all nine class pairs with distinct slot values (R2..R6)
    begin
      logic [1:0] spat [3];
      spat[0] = 2'b00; spat[1] = 2'b01; spat[2] = 2'b11;
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++) begin
          uniq(dn, up);
          step(1'b1, {spat[b], spat[a]}, dn, up, "");
        end
    end
    // R1: lower sign 0, upper sign 1 treated as P; B is P too -> PP row
    uniq(dn, up);
    step(1'b1, 4'b0010, dn, up, "R1");
    uniq(dn, up);
    step(1'b1, 4'b1000, dn, up, "R1");

    // R7: straddle/straddle ordering corners
    uniq(dn, up);
    dn[1] = 32'hc000_0000; dn[2] = 32'hbf80_0000;   // -2 vs -1, min -2
    up[0] = 32'hbf80_0000; up[3] = 32'hc000_0000;   // max -1
    step(1'b1, 4'b0101, dn, up, "R7");
    uniq(dn, up);
    dn[1] = 32'h0000_0000; dn[2] = 32'h8000_0000;   // +0 vs -0
    up[0] = 32'h8000_0000; up[3] = 32'h0000_0000;
    step(1'b1, 4'b0101, dn, up, "R7");
    uniq(dn, up);
    dn[1] = 32'h3f00_0000; dn[2] = 32'hbe00_0000;   // mixed signs
    up[0] = 32'hbe00_0000; up[3] = 32'h3f00_0000;
    step(1'b1, 4'b0101, dn, up, "R7");

    // idle gap for R9 hold
    repeat (4) step(1'b0, 4'b0, dn, up, "");

    // random traffic with gaps
    for (int i = 0; i < 600; i++) begin
      logic v;
      logic [3:0] s;
      v = ($urandom % 4) != 0;
      s = 4'($urandom);
      for (int k = 0; k < 4; k++) begin
        dn[k] = $urandom;
        up[k] = $urandom;
      end
      step(v, s, dn, up, "");
    end

    repeat (LAT + 2) step(1'b0, 4'b0, dn, up, "");
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R8: actual=%0d pending expected=0 pending", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule